// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block keeps a device in reset while its supplies ramp, and releases it only when every monitored rail is good. It reads one rail-good flag from an external comparator for the core rail, one for the pre-driver rail, and one for each of eight I/O bank rails. Every flag passes through a two-flop synchronizer before the state machine sees it. All user I/O stays tri-stated until the block reaches user mode. A strap input selects a short or a long reset delay. Time is measured by counting clock cycles against the `CYC_PER_MS` parameter.

The states are `ST_RESET`, `ST_WAIT_RAILS`, `ST_POR_DELAY`, `ST_CONFIG` and `ST_USER_MODE`. The transitions are:

- RESET→WAIT_RAILS: one cycle after the asynchronous reset is released, unless the fault flag is set.
- WAIT_RAILS→POR_DELAY: when all rails are good. The delay-select level is latched on this edge.
- WAIT_RAILS→RESET: when the rise-time window expires first. This sets the sticky fault flag, and the block then stays in RESET.
- POR_DELAY→WAIT_RAILS: when any rail drops. The delay counter clears.
- POR_DELAY→CONFIG: when the delay has elapsed.
- CONFIG→USER_MODE: always, after one cycle.
- USER_MODE→RESET: when the core rail drops (brown-out). The sequence then restarts.

Top module: `por_sequencer`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `io_tristate`=1, `cfg_start`=0, `user_mode`=0 and `rise_fault`=0.
- R2: `io_tristate` is 1 in every state except USER_MODE. It deasserts only in the cycle after the `cfg_start` pulse.
- R3: The block leaves WAIT_RAILS for the delay only when `core_ok`, `predrv_ok` and all bits of `io_bank_ok` (bit i = bank i) are 1 at the same time, after synchronization. If any one of them is missing, the block never reaches user mode.
- R4: Each rail flag passes through two flops. A change driven just after a clock edge reaches the state machine on the third rising edge after it.
- R5: With `delay_sel` low the delay is `LONG_MS` (100) ms, and with it high it is `SHORT_MS` (12) ms. POR_DELAY lasts exactly `ms*CYC_PER_MS` cycles. From the rails becoming good to `cfg_start` rising is therefore 3 + `ms*CYC_PER_MS` rising edges.
- R6: `delay_sel` is sampled once, on entry to POR_DELAY. Later changes do not alter the current delay.
- R7: If any rail drops during POR_DELAY, the block returns to WAIT_RAILS and the delay count restarts from zero.
- R8: `cfg_start` is high for exactly one cycle, on entry to CONFIG. `user_mode` rises in the following cycle.
- R9: In USER_MODE, loss of `predrv_ok` or of any `io_bank_ok` bit has no effect.
- R10: In USER_MODE, a drop of `core_ok` returns the block to RESET. `io_tristate` is 1 and `user_mode` is 0 three edges later, and the full sequence then restarts.
- R11: If the rails are not all good within `RISE_MS` (100) ms of entering WAIT_RAILS, `rise_fault` is set. It stays set, with the I/O tri-stated and no configuration start, until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of known frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ok | input | 1 | Core rail good (asynchronous) |
| io_bank_ok | input | N_IO_BANKS | I/O bank rails good, bit i = bank i |
| predrv_ok | input | 1 | Pre-driver rail good |
| delay_sel | input | 1 | 0 = long delay, 1 = short delay |
| io_tristate | output | 1 | 1 = user I/O tri-stated |
| cfg_start | output | 1 | One-cycle configuration start pulse |
| user_mode | output | 1 | Device is in user mode |
| rise_fault | output | 1 | Sticky rise-time timeout flag |

## Verification
The bench measures exact latencies from the rails becoming good to `cfg_start`, for both delay selections. An off-by-one counter, or a synchronizer with the wrong depth, shows up as a shifted cycle count.

Several corner cases each have their own test:

- A single missing rail, at each end of the bank vector and on the core and pre-driver rails. A design that ANDs too few flags would configure anyway.
- Flipping `delay_sel` mid-delay. A design that re-reads the pin would switch to the long delay.
- Dropping a bank rail during the delay. A design that does not clear its counter would finish early.
- Dropping non-core rails in user mode. A design that keeps watching them would reset.
- Letting the rise window expire. A design without the sticky flag would configure once the rails later came up.

// File: rtl/por_pkg.sv
package por_pkg;
    typedef enum logic [2:0] {
        ST_RESET,
        ST_WAIT_RAILS,
        ST_POR_DELAY,
        ST_CONFIG,
        ST_USER_MODE
    } por_state_e;
endpackage

// File: rtl/por_rail_sync.sv
module por_rail_sync #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/por_ms_timer.sv
module por_ms_timer #(
    parameter int unsigned CYC_PER_MS = 50000,
    parameter int unsigned MAX_MS     = 100
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         run,
    input  logic [$clog2(MAX_MS+1)-1:0]  limit_ms,
    output logic                         done
);
    localparam int unsigned MAX_CYC = MAX_MS * CYC_PER_MS;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit_cyc;

    assign limit_cyc = CW'(limit_ms) * CW'(CYC_PER_MS);
    assign done      = run && (cnt == limit_cyc - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (run && !done)  cnt <= cnt + CW'(1);
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_ms != '0) |-> (cnt < limit_cyc));
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
    import por_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 50000,
    parameter int unsigned N_IO_BANKS = 8,
    parameter int unsigned LONG_MS    = 100,
    parameter int unsigned SHORT_MS   = 12,
    parameter int unsigned RISE_MS    = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  core_ok,
    input  logic [N_IO_BANKS-1:0] io_bank_ok,
    input  logic                  predrv_ok,
    input  logic                  delay_sel,
    output logic                  io_tristate,
    output logic                  cfg_start,
    output logic                  user_mode,
    output logic                  rise_fault
);
    localparam int unsigned NR     = N_IO_BANKS + 2;
    localparam int unsigned DLY_MAX = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int unsigned DW     = $clog2(DLY_MAX + 1);
    localparam int unsigned RW     = $clog2(RISE_MS + 1);

    por_state_e    state, state_nx;
    logic [NR-1:0] rails_s;
    logic          core_s, all_ok;
    logic          sel_short;
    logic          dly_done, rise_done;
    logic [DW-1:0] dly_ms;

    // Synchronizer bit layout: [0] core, [N:1] banks, [N+1] pre-driver
    por_rail_sync #(.W(NR)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({predrv_ok, io_bank_ok, core_ok}),
        .q     (rails_s)
    );

    assign core_s = rails_s[0];
    assign all_ok = &rails_s;
    assign dly_ms = sel_short ? DW'(SHORT_MS) : DW'(LONG_MS);

    por_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MAX_MS(DLY_MAX)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state != ST_POR_DELAY),
        .run      (state == ST_POR_DELAY),
        .limit_ms (dly_ms),
        .done     (dly_done)
    );

    por_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MAX_MS(RISE_MS)) u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == ST_RESET),
        .run      (state == ST_WAIT_RAILS),
        .limit_ms (RW'(RISE_MS)),
        .done     (rise_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET:      state_nx = rise_fault ? ST_RESET : ST_WAIT_RAILS;
            ST_WAIT_RAILS: begin
                if (all_ok)         state_nx = ST_POR_DELAY;
                else if (rise_done) state_nx = ST_RESET;
            end
            ST_POR_DELAY: begin
                if (!all_ok)        state_nx = ST_WAIT_RAILS;
                else if (dly_done)  state_nx = ST_CONFIG;
            end
            ST_CONFIG:     state_nx = ST_USER_MODE;
            ST_USER_MODE:  if (!core_s) state_nx = ST_RESET;
            default:       state_nx = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RESET;
            sel_short  <= 1'b0;
            rise_fault <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT_RAILS && all_ok)
                sel_short <= delay_sel;
            if (state == ST_WAIT_RAILS && !all_ok && rise_done)
                rise_fault <= 1'b1;
        end
    end

    always_comb begin
        io_tristate = (state != ST_USER_MODE);
        cfg_start   = (state == ST_CONFIG);
        user_mode   = (state == ST_USER_MODE);
    end

    assert_cfg_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (!cfg_start && user_mode));
    assert_cfg_rails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |-> $past(all_ok));
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_tristate) |-> $past(cfg_start));
    assert_brownout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && !core_s) |=> (io_tristate && !user_mode));
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_fault |=> rise_fault);
    assert_fault_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_fault |-> (io_tristate && !cfg_start));
endmodule

// File: tb/por_sequencer_tb.sv
module por_sequencer_tb;
    localparam int CYC = 10;
    localparam int SHORT_LAT = 3 + 12 * CYC;
    localparam int LONG_LAT  = 3 + 100 * CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_ok = 1'b0;
    logic [7:0] io_bank_ok = '0;
    logic       predrv_ok = 1'b0;
    logic       delay_sel = 1'b1;
    logic       io_tristate, cfg_start, user_mode, rise_fault;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    always #2 clk = ~clk;

    por_sequencer #(.CYC_PER_MS(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_ok(core_ok), .io_bank_ok(io_bank_ok),
        .predrv_ok(predrv_ok), .delay_sel(delay_sel), .io_tristate(io_tristate),
        .cfg_start(cfg_start), .user_mode(user_mode), .rise_fault(rise_fault)
    );

    // {core, banks[7:0], predrv, expected user_mode}
    localparam logic [10:0] TBL [6] = '{
        11'b1_11111111_1_1,
        11'b0_11111111_1_0,
        11'b1_11111110_1_0,
        11'b1_01111111_1_0,
        11'b1_11111111_0_0,
        11'b0_00000000_0_0
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_rails(input logic c, input logic [7:0] b, input logic p);
        core_ok = c; io_bank_ok = b; predrv_ok = p;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        set_rails(1'b0, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int n);
        n = -1;
        for (int i = 1; i <= 2000; i++) begin
            @(negedge clk);
            if (cfg_start) begin
                n = i;
                break;
            end
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc_cnt);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        // R1: reset state
        wait_n(2);
        check("R1 tristate in reset", io_tristate, 1);
        check("R1 cfg in reset", cfg_start, 0);
        check("R1 user in reset", user_mode, 0);
        check("R1 fault in reset", rise_fault, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tristate after release", io_tristate, 1);

        // R3: rail combination table
        foreach (TBL[k]) begin
            do_reset();
            delay_sel = 1'b1;
            set_rails(TBL[k][10], TBL[k][9:2], TBL[k][1]);
            wait_n(200);
            check($sformatf("R3 pattern %0d user_mode", k), user_mode, int'(TBL[k][0]));
        end

        // R4 R5: short delay latency, R2 R8 pulse and release
        do_reset();
        delay_sel = 1'b1;
        set_rails(1'b1, 8'hFF, 1'b1);
        measure(lat);
        check("R5 R4 short latency", lat, SHORT_LAT);
        check("R2 tristate during cfg", io_tristate, 1);
        @(negedge clk);
        check("R8 cfg one cycle", cfg_start, 0);
        check("R8 user after cfg", user_mode, 1);
        check("R2 released in user", io_tristate, 0);

        // R9: non-core loss ignored
        set_rails(1'b1, 8'h00, 1'b0);
        wait_n(20);
        check("R9 user kept", user_mode, 1);
        check("R9 io still driven", io_tristate, 0);

        // R10: brown-out on core
        set_rails(1'b0, 8'hFF, 1'b1);
        wait_n(3);
        check("R10 tristate on brownout", io_tristate, 1);
        check("R10 user dropped", user_mode, 0);
        set_rails(1'b1, 8'hFF, 1'b1);
        measure(lat);
        check("R10 restart latency", lat, SHORT_LAT);

        // R5: long delay
        do_reset();
        delay_sel = 1'b0;
        set_rails(1'b1, 8'hFF, 1'b1);
        measure(lat);
        check("R5 long latency", lat, LONG_LAT);

        // R6: delay_sel change mid-sequence ignored
        do_reset();
        delay_sel = 1'b1;
        set_rails(1'b1, 8'hFF, 1'b1);
        wait_n(10);
        delay_sel = 1'b0;
        measure(lat);
        check("R6 latched select", lat + 10, SHORT_LAT);

        // R7: drop during delay restarts count
        do_reset();
        delay_sel = 1'b1;
        set_rails(1'b1, 8'hFF, 1'b1);
        wait_n(50);
        set_rails(1'b1, 8'hF7, 1'b1);
        wait_n(5);
        check("R7 no cfg while dropped", cfg_start, 0);
        set_rails(1'b1, 8'hFF, 1'b1);
        measure(lat);
        check("R7 restart latency", lat, SHORT_LAT);

        // R11: rise-time timeout
        do_reset();
        delay_sel = 1'b1;
        wait_n(1100);
        check("R11 fault set", rise_fault, 1);
        check("R11 tristate on fault", io_tristate, 1);
        set_rails(1'b1, 8'hFF, 1'b1);
        wait_n(300);
        check("R11 no user after fault", user_mode, 0);
        check("R11 fault sticky", rise_fault, 1);
        do_reset();
        @(negedge clk);
        check("R11 fault cleared by reset", rise_fault, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule